// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

A compact stored-program processor built around a single 16-bit accumulator. Program words and data words live in one shared memory of 1024 entries, and every memory access, whether it fetches an instruction or moves an operand, passes through an address holding register and a data holding register. A control sequencer walks each instruction through a fetch, a decode and an execute phase. Each phase takes several clock cycles.

Each instruction word carries a 6-bit operation code in bits 15:10 and a 10-bit memory address in bits 9:0. The core supports these operations:
- loading the accumulator from memory;
- storing the accumulator to memory;
- wrapping add and subtract;
- an unsigned multiply that spreads a double-width product over the accumulator and a companion low-half register;
- an unconditional jump and a jump taken when the accumulator is zero;
- a halt.

The core is meant to sit beside a synchronous single-port RAM that has one cycle of read latency. The halt flag, the accumulator and the low-half register are brought out for observation.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, the core keeps `halted` low, `acc_dbg` and `mq_dbg` at zero, `mem_we` low and `mem_addr` at 0. After release, the first instruction is fetched from address 0.
- R2: Instructions run in address order. The program counter advances by one during every fetch, so it always names the next instruction.
- R3: Opcode 000001 (load) copies the memory word at the address field into the accumulator.
- R4: Opcode 000010 (store) writes the accumulator to the address field in a single-cycle `mem_we` pulse, and it leaves the accumulator unchanged.
- R5: Opcode 000011 (add) and opcode 000100 (subtract) combine the accumulator with the memory operand and write the result back to the accumulator, modulo 2^16.
- R6: Opcode 000101 (multiply) forms the unsigned 32-bit product of the accumulator and the memory operand, and the low 16 bits go to `mq_dbg`. When the upper half is nonzero, the accumulator takes the upper half. Otherwise it takes the low half, so that a load, multiply, add sequence yields a*b+c.
- R7: Opcode 000110 (jump) continues execution at the address field.
- R8: Opcode 000111 (jump if zero) continues at the address field when the accumulator is zero, and otherwise at the next word.
- R9: Opcode 111111 (halt) raises `halted`, which stays high until reset. While halted, no memory writes occur and the accumulator holds its value.
- R10: Every other opcode does nothing apart from advancing to the next word.
- R11: From the reset release until the following instruction begins, each instruction takes a fixed number of clock edges: 5 for no-op, jump, jump if zero and halt; 6 for store; 8 for load, add and subtract; 9 for multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 10 | Shared memory address, driven from the address holding register |
| mem_wdata | output | 16 | Write data, driven from the data holding register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt has executed |
| acc_dbg | output | 16 | Accumulator value |
| mq_dbg | output | 16 | Low-half product register value |

## Verification
Each result is due a fixed number of edges after reset release. That number is the sum of the per-instruction costs in R11: one wait cycle sits between presenting an address and capturing the data, and multiply adds one cycle to load its operand registers. Each directed program has a predicted edge count at which `halted` must first read high. The bench counts falling edges from the reset release and compares the count at the first high `halted` against that prediction. The accumulator, the low-half register and the memory contents are read only after that point. This means every check of an execution result is taken after the last register on its path has settled.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 10;
  localparam int OP_W   = WORD_W - ADDR_W;

  localparam logic [OP_W-1:0] OP_LOAD  = 6'b000001;
  localparam logic [OP_W-1:0] OP_STORE = 6'b000010;
  localparam logic [OP_W-1:0] OP_ADD   = 6'b000011;
  localparam logic [OP_W-1:0] OP_SUB   = 6'b000100;
  localparam logic [OP_W-1:0] OP_MUL   = 6'b000101;
  localparam logic [OP_W-1:0] OP_JMP   = 6'b000110;
  localparam logic [OP_W-1:0] OP_JZ    = 6'b000111;
  localparam logic [OP_W-1:0] OP_HALT  = 6'b111111;

  typedef enum logic [3:0] {
    ST_FMAR, ST_FWAIT, ST_FCAP, ST_FIR, ST_DEC,
    ST_OWAIT, ST_OCAP, ST_MSET, ST_EXEC, ST_STORE, ST_HALT
  } cpu_state_e;

  function automatic logic [WORD_W-1:0] f_addsub(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b,
                                                 input logic sub);
    return sub ? a - b : a + b;
  endfunction

  function automatic logic [2*WORD_W-1:0] f_mul(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    return {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b};
  endfunction

  // Accumulator value after a multiply: upper half if nonzero, else lower half
  function automatic logic [WORD_W-1:0] f_mul_acc(input logic [2*WORD_W-1:0] p);
    return (p[2*WORD_W-1:WORD_W] != '0) ? p[2*WORD_W-1:WORD_W] : p[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    acc,
  input  logic [W-1:0]    opnd,
  input  logic [W-1:0]    x_reg,
  input  logic [W-1:0]    mq_reg,
  output logic [W-1:0]    arith_res,
  output logic [W-1:0]    mul_hi_sel,
  output logic [W-1:0]    mul_lo
);
  logic [2*W-1:0] prod;

  always_comb begin
    arith_res  = f_addsub(acc, opnd, op == OP_SUB);
    prod       = f_mul(x_reg, mq_reg);
    mul_hi_sel = f_mul_acc(prod);
    mul_lo     = prod[W-1:0];
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            acc_zero,
  output logic            mar_from_pc,
  output logic            mar_from_ir,
  output logic            pc_inc,
  output logic            pc_load,
  output logic            mdr_from_mem,
  output logic            mdr_from_acc,
  output logic            ir_load,
  output logic            acc_from_mdr,
  output logic            alu_wr,
  output logic            mul_setup,
  output logic            mul_wr,
  output logic            mem_we,
  output logic            halted
);
  cpu_state_e state_q, state_d;
  logic needs_operand;

  assign needs_operand = (opcode == OP_LOAD) || (opcode == OP_ADD) ||
                         (opcode == OP_SUB)  || (opcode == OP_MUL);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_FMAR;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d      = state_q;
    mar_from_pc  = 1'b0;
    mar_from_ir  = 1'b0;
    pc_inc       = 1'b0;
    pc_load      = 1'b0;
    mdr_from_mem = 1'b0;
    mdr_from_acc = 1'b0;
    ir_load      = 1'b0;
    acc_from_mdr = 1'b0;
    alu_wr       = 1'b0;
    mul_setup    = 1'b0;
    mul_wr       = 1'b0;
    mem_we       = 1'b0;
    halted       = 1'b0;
    unique case (state_q)
      ST_FMAR:  begin mar_from_pc = 1'b1; state_d = ST_FWAIT; end
      ST_FWAIT: begin pc_inc = 1'b1; state_d = ST_FCAP; end
      ST_FCAP:  begin mdr_from_mem = 1'b1; state_d = ST_FIR; end
      ST_FIR:   begin ir_load = 1'b1; state_d = ST_DEC; end
      ST_DEC: begin
        state_d = ST_FMAR;
        if (needs_operand) begin
          mar_from_ir = 1'b1;
          state_d     = ST_OWAIT;
        end else if (opcode == OP_STORE) begin
          mar_from_ir  = 1'b1;
          mdr_from_acc = 1'b1;
          state_d      = ST_STORE;
        end else if (opcode == OP_JMP) begin
          pc_load = 1'b1;
        end else if (opcode == OP_JZ) begin
          pc_load = acc_zero;
        end else if (opcode == OP_HALT) begin
          state_d = ST_HALT;
        end
      end
      ST_OWAIT: state_d = ST_OCAP;
      ST_OCAP: begin
        mdr_from_mem = 1'b1;
        state_d      = (opcode == OP_MUL) ? ST_MSET : ST_EXEC;
      end
      ST_MSET: begin mul_setup = 1'b1; state_d = ST_EXEC; end
      ST_EXEC: begin
        acc_from_mdr = (opcode == OP_LOAD);
        alu_wr       = (opcode == OP_ADD) || (opcode == OP_SUB);
        mul_wr       = (opcode == OP_MUL);
        state_d      = ST_FMAR;
      end
      ST_STORE: begin mem_we = 1'b1; state_d = ST_FMAR; end
      ST_HALT:  halted = 1'b1;
      default:  state_d = ST_FMAR;
    endcase
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic [DW-1:0] acc_dbg,
  output logic [DW-1:0] mq_dbg
);
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mdr_q, ir_q, acc_q, mq_q, x_q;
  logic [DW-1:0] arith_res, mul_hi_sel, mul_lo;
  logic mar_from_pc, mar_from_ir, pc_inc, pc_load, mdr_from_mem, mdr_from_acc;
  logic ir_load, acc_from_mdr, alu_wr, mul_setup, mul_wr;
  logic [OP_W-1:0] ir_op;
  logic [AW-1:0]   ir_addr;

  assign ir_op   = ir_q[DW-1:AW];
  assign ir_addr = ir_q[AW-1:0];

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(ir_op), .acc_zero(acc_q == '0),
    .mar_from_pc(mar_from_pc), .mar_from_ir(mar_from_ir),
    .pc_inc(pc_inc), .pc_load(pc_load),
    .mdr_from_mem(mdr_from_mem), .mdr_from_acc(mdr_from_acc),
    .ir_load(ir_load), .acc_from_mdr(acc_from_mdr), .alu_wr(alu_wr),
    .mul_setup(mul_setup), .mul_wr(mul_wr), .mem_we(mem_we), .halted(halted)
  );

  acc_cpu_alu #(.W(DW)) u_alu (
    .op(ir_op), .acc(acc_q), .opnd(mdr_q), .x_reg(x_q), .mq_reg(mq_q),
    .arith_res(arith_res), .mul_hi_sel(mul_hi_sel), .mul_lo(mul_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      mq_q  <= '0;
      x_q   <= '0;
    end else begin
      if (mar_from_pc)       mar_q <= pc_q;
      else if (mar_from_ir)  mar_q <= ir_addr;
      if (pc_inc)            pc_q  <= pc_q + 1'b1;
      else if (pc_load)      pc_q  <= ir_addr;
      if (mdr_from_mem)      mdr_q <= mem_rdata;
      else if (mdr_from_acc) mdr_q <= acc_q;
      if (ir_load)           ir_q  <= mdr_q;
      if (acc_from_mdr)      acc_q <= mdr_q;
      else if (alu_wr)       acc_q <= arith_res;
      else if (mul_wr)       acc_q <= mul_hi_sel;
      if (mul_setup) begin
        mq_q <= mdr_q;
        x_q  <= acc_q;
      end else if (mul_wr) begin
        mq_q <= mul_lo;
      end
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign acc_dbg   = acc_q;
  assign mq_dbg    = mq_q;
endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halted,
  input logic          mem_we,
  input logic [AW-1:0] pc,
  input logic          pc_inc,
  input logic          pc_load,
  input logic [AW-1:0] ir_addr,
  input logic          ld_commit,
  input logic [DW-1:0] mdr,
  input logic [DW-1:0] acc
);
  // R4
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && $stable(acc)));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> pc == $past(pc) + 1'b1);
  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> pc == $past(ir_addr));
  // R3
  load_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_commit |=> acc == $past(mdr));
endmodule

bind acc_cpu_core acc_cpu_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .mem_we(mem_we),
  .pc(pc_q), .pc_inc(pc_inc), .pc_load(pc_load), .ir_addr(ir_addr),
  .ld_commit(acc_from_mdr), .mdr(mdr_q), .acc(acc_q)
);

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata, acc_dbg, mq_dbg;
  logic        mem_we, halted;
  logic [15:0] mem [1024];
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  int checks = 0, fails = 0, writes = 0;

  always #5 clk = ~clk;

  acc_cpu_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .acc_dbg(acc_dbg), .mq_dbg(mq_dbg)
  );

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (mem_we && rst_n) writes <= writes + 1;
  end

  function automatic logic [15:0] ins(input logic [5:0] op, input logic [9:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  // Releases reset and counts edges until halted is first seen high
  task automatic run(output int cyc);
    @(negedge clk);
    writes = 0;
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    hold_reset();
    put(10'd0, ins(6'b111111, 10'd0));
    @(negedge clk);
    chk("R1 halted", {31'd0, halted}, 32'd0);
    chk("R1 acc", {16'd0, acc_dbg}, 32'd0);
    chk("R1 mq", {16'd0, mq_dbg}, 32'd0);
    chk("R1 we", {31'd0, mem_we}, 32'd0);
    chk("R1 addr", {22'd0, mem_addr}, 32'd0);
  endtask

  task automatic t_halt_only();
    int cyc;
    hold_reset();
    put(10'd0, ins(6'b111111, 10'd0));
    run(cyc);
    chk("R1 R11 halt at address 0 after 5 edges", cyc, 5);
  endtask

  task automatic t_load_store();
    int cyc;
    hold_reset();
    put(10'd0, ins(6'b000001, 10'd100));
    put(10'd1, ins(6'b000010, 10'd101));
    put(10'd2, ins(6'b111111, 10'd0));
    put(10'd100, 16'h1234);
    put(10'd101, 16'h0000);
    run(cyc);
    chk("R11 load+store+halt cycles", cyc, 19);
    chk("R3 load acc", {16'd0, acc_dbg}, 32'h1234);
    chk("R4 stored word", {16'd0, mem[101]}, 32'h1234);
    chk("R4 single write", writes, 1);
    repeat (20) @(negedge clk);
    chk("R9 halt sticky", {31'd0, halted}, 32'd1);
    chk("R9 no writes while halted", writes, 1);
    chk("R9 acc held", {16'd0, acc_dbg}, 32'h1234);
  endtask

  task automatic t_madd();
    int cyc;
    hold_reset();
    put(10'd0, ins(6'b000001, 10'd300));
    put(10'd1, ins(6'b000101, 10'd301));
    put(10'd2, ins(6'b000011, 10'd302));
    put(10'd3, ins(6'b111111, 10'd0));
    put(10'd300, 16'd7);
    put(10'd301, 16'd6);
    put(10'd302, 16'd5);
    run(cyc);
    chk("R11 load+mul+add+halt cycles", cyc, 30);
    chk("R6 R5 a*b+c", {16'd0, acc_dbg}, 32'd47);
    chk("R6 mq low half", {16'd0, mq_dbg}, 32'd42);
  endtask

  task automatic t_mul_big();
    int cyc;
    logic [31:0] p;
    hold_reset();
    put(10'd0, ins(6'b000001, 10'd310));
    put(10'd1, ins(6'b000101, 10'd311));
    put(10'd2, ins(6'b111111, 10'd0));
    put(10'd310, 16'hF234);
    put(10'd311, 16'h0F00);
    run(cyc);
    p = 32'hF234 * 32'h0F00;
    chk("R6 acc takes upper half", {16'd0, acc_dbg}, {16'd0, p[31:16]});
    chk("R6 mq takes lower half", {16'd0, mq_dbg}, {16'd0, p[15:0]});
    chk("R11 load+mul+halt cycles", cyc, 22);
  endtask

  task automatic t_wrap();
    int cyc;
    hold_reset();
    put(10'd0, ins(6'b000001, 10'd320));
    put(10'd1, ins(6'b000011, 10'd321));
    put(10'd2, ins(6'b000010, 10'd323));
    put(10'd3, ins(6'b000100, 10'd322));
    put(10'd4, ins(6'b111111, 10'd0));
    put(10'd320, 16'hFFFF);
    put(10'd321, 16'd2);
    put(10'd322, 16'd3);
    put(10'd323, 16'd0);
    run(cyc);
    chk("R5 add wrap", {16'd0, mem[323]}, 32'd1);
    chk("R5 sub wrap", {16'd0, acc_dbg}, 32'hFFFE);
    chk("R11 mixed cycles", cyc, 35);
  endtask

  task automatic t_jmp();
    int cyc;
    hold_reset();
    put(10'd0, ins(6'b000110, 10'd5));
    put(10'd1, ins(6'b000001, 10'd330));
    put(10'd5, ins(6'b111111, 10'd0));
    put(10'd330, 16'd77);
    run(cyc);
    chk("R7 skipped load", {16'd0, acc_dbg}, 32'd0);
    chk("R7 jump cycles", cyc, 10);
  endtask

  task automatic t_jz();
    int cyc;
    hold_reset();
    put(10'd0, ins(6'b000001, 10'd200));
    put(10'd1, ins(6'b000111, 10'd4));
    put(10'd2, ins(6'b000001, 10'd201));
    put(10'd3, ins(6'b111111, 10'd0));
    put(10'd4, ins(6'b000001, 10'd202));
    put(10'd5, ins(6'b000111, 10'd7));
    put(10'd6, ins(6'b111111, 10'd0));
    put(10'd7, ins(6'b000001, 10'd201));
    put(10'd8, ins(6'b111111, 10'd0));
    put(10'd200, 16'd0);
    put(10'd201, 16'd9);
    put(10'd202, 16'd3);
    run(cyc);
    chk("R8 taken then not taken", {16'd0, acc_dbg}, 32'd3);
    chk("R8 cycles", cyc, 31);
  endtask

  task automatic t_nop();
    int cyc;
    hold_reset();
    put(10'd0, ins(6'b000001, 10'd340));
    put(10'd1, ins(6'b000000, 10'd341));
    put(10'd2, ins(6'b001000, 10'd341));
    put(10'd3, ins(6'b111111, 10'd0));
    put(10'd340, 16'h00AB);
    put(10'd341, 16'h5555);
    run(cyc);
    chk("R10 acc unchanged", {16'd0, acc_dbg}, 32'h00AB);
    chk("R10 no writes", writes, 0);
    chk("R10 target word untouched", {16'd0, mem[341]}, 32'h5555);
    chk("R2 R11 nop cycles", cyc, 23);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_halt_only();
        t_load_store();
        t_madd();
        t_mul_big();
        t_wrap();
        t_jmp();
        t_jz();
        t_nop();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule